// File: doc/BRIEF.md
# Privilege-Checked Special Register Unit

This block holds the special-purpose registers of a small processor core that runs in one of two modes, user or supervisor. It serves move-from and move-to requests from the core on a single request port. It checks every request against the supervisor bit of the status register and against the minimum mode each register demands. When a request breaks that rule, or names an address that holds no register, the block raises an exception in place of the access. It also carries out trap and syscall entry and the return-from-exception instruction. In every case it reports a cause code and a redirect program counter for the fetch logic.

A 16-bit register address is split into a group number (the address shifted right by 11) and an 11-bit index. Only group 0 is populated.

Exception entry is the only way up into supervisor mode. It copies the status register into a saved-status register, records the program counter of the offending operation, sets the supervisor bit and redirects fetch to the vector address. A return from exception restores the status register from the saved copy and redirects to the saved program counter. If the saved copy shows user mode, the core really does drop to user mode. All results are registered and appear on the outputs in the cycle after the request or instruction is presented.

Top module: `priv_spr_unit`

## Requirements
- R1: After reset the status register reads 0x8001, `supervisor` is 1, and `exc_valid`, `redirect_valid` and `rd_valid` are 0.
- R2: The group number is address bits [15:11] and the index is bits [10:0]. Only group 0 holds registers, at index 0x11 (status), 0x12 (previous PC), 0x14 (debug status), 0x20 (exception PC), 0x30 (user scratch) and 0x40 (saved status). A request to any other address, in either mode, raises cause 3 (unimplemented) and returns `rd_data` = 0.
- R3: In supervisor mode every implemented register can be written and read back. A read answers one cycle after the request with `rd_valid` = 1. Writing 0 to the status register leaves it at 0x8000, which is user mode.
- R4: A user-mode read of any register other than the user scratch raises cause 1 (privilege violation). In the same cycle it returns `rd_valid` = 1 with `rd_data` = 0.
- R5: A user-mode write to any register other than the user scratch raises cause 1. The write data lands in no register. The only state change is the exception entry of R7.
- R6: The user scratch register (index 0x30) can be written and read in user mode without an exception and without a mode change.
- R7: Any exception performs entry in the same registered cycle. `exc_valid` = 1 with its cause, `redirect_valid` = 1, `redirect_pc` = 0x200 and `supervisor` = 1. The saved status receives the old status register and the exception PC receives `cur_pc`. A trap (`instr_class` 1) raises cause 4 and a syscall (`instr_class` 2) raises cause 5.
- R8: A return from exception (`instr_class` 3) in user mode raises cause 2 (illegal instruction) and enters supervisor mode.
- R9: A return from exception in supervisor mode raises no exception. It sets the status register to the saved status with bit 15 forced to 1 and gives `redirect_valid` = 1 with `redirect_pc` equal to the exception PC. A saved status with bit 0 clear leaves the core in user mode.
- R10: `supervisor` goes from 0 to 1 only in a cycle where `exc_valid` is 1.
- R11: Each instruction presented with `instr_valid` (`instr_class` 0 included) records `cur_pc` in the previous-PC register. `instr_class` 0 raises no exception and no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present (ignored while instr_valid is 1) |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_addr | input | 16 | Register address, group in [15:11], index in [10:0] |
| req_wdata | input | 32 | Write data |
| instr_valid | input | 1 | Instruction event present |
| instr_class | input | 2 | 0 other, 1 trap, 2 syscall, 3 return from exception |
| cur_pc | input | 32 | Program counter of the current request or instruction |
| rd_valid | output | 1 | Read response present |
| rd_data | output | 32 | Read data, zero when the read faulted |
| exc_valid | output | 1 | Exception raised |
| exc_cause | output | 3 | 1 privilege, 2 illegal instruction, 3 unimplemented, 4 trap, 5 syscall |
| redirect_valid | output | 1 | Fetch must jump to redirect_pc |
| redirect_pc | output | 32 | Vector address or return address |
| supervisor | output | 1 | Current mode, 1 = supervisor |

## Verification
Each register is read and written in both modes.

- Supervisor accesses show that decode and storage are right.
- User accesses show that the privilege filter refuses exactly the protected set and lets the user scratch through.
- Read-back after a refused user write tells a write that was dropped apart from one that landed before the entry.

Addresses with a valid index in a foreign group, and holes in group 0, separate a full address compare from an index-only one. Returns from exception use saved status values with the supervisor bit clear and set. These show that the mode really drops, that bit 15 is forced, and that the return in user mode is trapped as illegal.

// File: rtl/spr_pkg.sv
package spr_pkg;

  typedef enum logic [1:0] {
    IC_OTHER   = 2'd0,
    IC_TRAP    = 2'd1,
    IC_SYSCALL = 2'd2,
    IC_RFE     = 2'd3
  } iclass_e;

  typedef enum logic [2:0] {
    EC_NONE    = 3'd0,
    EC_PRIV    = 3'd1,
    EC_ILLEGAL = 3'd2,
    EC_UNIMPL  = 3'd3,
    EC_TRAP    = 3'd4,
    EC_SYSCALL = 3'd5
  } ecause_e;

  // register slots and their group-0 indices
  localparam int NREG     = 6;
  localparam int SLOT_SR  = 0;
  localparam int SLOT_PPC = 1;
  localparam int SLOT_DSR = 2;
  localparam int SLOT_EPC = 3;
  localparam int SLOT_ESR = 4;
  localparam int SLOT_USR = 5;

  localparam int SLOT_INDEX [NREG] = '{32'h11, 32'h12, 32'h14, 32'h20, 32'h40, 32'h30};
  // 1 = reachable from user mode
  localparam logic [NREG-1:0] SLOT_USER_OK = 6'b100000;

endpackage

// File: rtl/spr_addr_decode.sv
module spr_addr_decode
  import spr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int GRP_SHIFT = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit,
  output logic              impl,
  output logic              need_sup
);
  localparam int GRP_W = ADDR_W - GRP_SHIFT;

  logic [GRP_W-1:0]     group_num;
  logic [GRP_SHIFT-1:0] index_num;

  assign group_num = addr[ADDR_W-1:GRP_SHIFT];
  assign index_num = addr[GRP_SHIFT-1:0];

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    assign hit[i] = (group_num == '0) && (int'(index_num) == SLOT_INDEX[i]);
  end

  assign impl     = |hit;
  assign need_sup = |(hit & ~SLOT_USER_OK);

endmodule

// File: rtl/spr_access_check.sv
module spr_access_check
  import spr_pkg::*;
(
  input  logic    req_valid,
  input  logic    req_write,
  input  logic    impl,
  input  logic    need_sup,
  input  logic    cur_sup,
  input  logic    instr_valid,
  input  iclass_e instr_class,
  output logic    fault,
  output ecause_e cause,
  output logic    do_read,
  output logic    do_write,
  output logic    do_rfe,
  output logic    rd_resp
);
  always_comb begin
    fault    = 1'b0;
    cause    = EC_NONE;
    do_read  = 1'b0;
    do_write = 1'b0;
    do_rfe   = 1'b0;
    rd_resp  = 1'b0;
    if (instr_valid) begin
      unique case (instr_class)
        IC_TRAP:    begin fault = 1'b1; cause = EC_TRAP;    end
        IC_SYSCALL: begin fault = 1'b1; cause = EC_SYSCALL; end
        IC_RFE: begin
          if (cur_sup) do_rfe = 1'b1;
          else begin fault = 1'b1; cause = EC_ILLEGAL; end
        end
        default: ;
      endcase
    end else if (req_valid) begin
      rd_resp = !req_write;
      if (!impl) begin
        fault = 1'b1; cause = EC_UNIMPL;
      end else if (need_sup && !cur_sup) begin
        fault = 1'b1; cause = EC_PRIV;
      end else begin
        do_read  = !req_write;
        do_write = req_write;
      end
    end
  end
endmodule

// File: rtl/spr_state.sv
module spr_state
  import spr_pkg::*;
#(
  parameter int                 DATA_W   = 32,
  parameter int                 SUP_BIT  = 0,
  parameter int                 FIX_BIT  = 15,
  parameter logic [DATA_W-1:0]  VEC_ADDR = 32'h200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREG-1:0]   hit,
  input  logic              fault,
  input  ecause_e           cause,
  input  logic              do_read,
  input  logic              do_write,
  input  logic              do_rfe,
  input  logic              rd_resp,
  input  logic              note_pc,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cur_pc,
  output logic              rd_valid_q,
  output logic [DATA_W-1:0] rd_data_q,
  output logic              exc_valid_q,
  output ecause_e           exc_cause_q,
  output logic              redirect_valid_q,
  output logic [DATA_W-1:0] redirect_pc_q,
  output logic              sup_q
);
  localparam logic [DATA_W-1:0] SR_FIXED = DATA_W'(1) << FIX_BIT;
  localparam logic [DATA_W-1:0] SR_SUP   = DATA_W'(1) << SUP_BIT;
  localparam logic [DATA_W-1:0] SR_RESET = SR_FIXED | SR_SUP;

  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) rd_mux = rd_mux | regs[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      regs[SLOT_SR]    <= SR_RESET;
      rd_valid_q       <= 1'b0;
      rd_data_q        <= '0;
      exc_valid_q      <= 1'b0;
      exc_cause_q      <= EC_NONE;
      redirect_valid_q <= 1'b0;
      redirect_pc_q    <= '0;
    end else begin
      rd_valid_q       <= rd_resp;
      rd_data_q        <= do_read ? rd_mux : '0;
      exc_valid_q      <= fault;
      exc_cause_q      <= cause;
      redirect_valid_q <= fault | do_rfe;
      redirect_pc_q    <= fault ? VEC_ADDR : (do_rfe ? regs[SLOT_EPC] : '0);
      if (note_pc) regs[SLOT_PPC] <= cur_pc;
      if (do_write) begin
        for (int i = 0; i < NREG; i++)
          if (hit[i]) regs[i] <= (i == SLOT_SR) ? (wdata | SR_FIXED) : wdata;
      end
      if (fault) begin
        regs[SLOT_ESR] <= regs[SLOT_SR];
        regs[SLOT_EPC] <= cur_pc;
        regs[SLOT_SR]  <= regs[SLOT_SR] | SR_SUP;
      end
      if (do_rfe) regs[SLOT_SR] <= regs[SLOT_ESR] | SR_FIXED;
    end
  end

  assign sup_q = regs[SLOT_SR][SUP_BIT];

  // R10: mode rises only through exception entry
  a_r10_sup_rise_needs_exc: assert property (@(posedge clk) disable iff (rst)
    $rose(sup_q) |-> exc_valid_q);

  // R7: an exception always lands in supervisor mode
  a_r7_exc_enters_sup: assert property (@(posedge clk) disable iff (rst)
    exc_valid_q |-> sup_q);

  // R4: a faulting cycle never carries read data
  a_r4_fault_read_zero: assert property (@(posedge clk) disable iff (rst)
    exc_valid_q |-> (rd_data_q == '0));

  // R9: a return redirects to the exception PC held before it
  a_r9_rfe_to_epc: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(do_rfe)) |-> (redirect_valid_q && redirect_pc_q == $past(regs[SLOT_EPC])));

endmodule

// File: rtl/priv_spr_unit.sv
module priv_spr_unit
  import spr_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                GRP_SHIFT = 11,
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] VEC_ADDR  = 32'h200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              instr_valid,
  input  logic [1:0]        instr_class,
  input  logic [DATA_W-1:0] cur_pc,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              exc_valid,
  output logic [2:0]        exc_cause,
  output logic              redirect_valid,
  output logic [DATA_W-1:0] redirect_pc,
  output logic              supervisor
);
  logic [NREG-1:0] hit;
  logic            impl, need_sup;
  logic            fault, do_read, do_write, do_rfe, rd_resp;
  ecause_e         cause, cause_q;

  spr_addr_decode #(.ADDR_W(ADDR_W), .GRP_SHIFT(GRP_SHIFT)) u_dec (
    .addr(req_addr), .hit(hit), .impl(impl), .need_sup(need_sup)
  );

  spr_access_check u_chk (
    .req_valid(req_valid), .req_write(req_write), .impl(impl), .need_sup(need_sup),
    .cur_sup(supervisor), .instr_valid(instr_valid), .instr_class(iclass_e'(instr_class)),
    .fault(fault), .cause(cause), .do_read(do_read), .do_write(do_write),
    .do_rfe(do_rfe), .rd_resp(rd_resp)
  );

  spr_state #(.DATA_W(DATA_W), .VEC_ADDR(VEC_ADDR)) u_st (
    .clk(clk), .rst(rst), .hit(hit), .fault(fault), .cause(cause),
    .do_read(do_read), .do_write(do_write), .do_rfe(do_rfe), .rd_resp(rd_resp),
    .note_pc(instr_valid), .wdata(req_wdata), .cur_pc(cur_pc),
    .rd_valid_q(rd_valid), .rd_data_q(rd_data), .exc_valid_q(exc_valid),
    .exc_cause_q(cause_q), .redirect_valid_q(redirect_valid),
    .redirect_pc_q(redirect_pc), .sup_q(supervisor)
  );

  assign exc_cause = cause_q;

  // R8: return from exception in user mode is illegal
  a_r8_user_rfe_illegal: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_valid && instr_class == 2'd3 && !supervisor))
      |-> (exc_valid && exc_cause == 3'd2));

  // R5: user write to a protected register is refused with a privilege fault
  a_r5_user_write_refused: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && req_write && !instr_valid && !supervisor && need_sup))
      |-> (exc_valid && exc_cause == 3'd1));

endmodule

// File: tb/sim_priv_spr_unit.sv
`timescale 1ns/1ps
module sim_priv_spr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        instr_valid = 1'b0;
  logic [1:0]  instr_class = 2'd0;
  logic [31:0] cur_pc = '0;
  logic        rd_valid, exc_valid, redirect_valid, supervisor;
  logic [31:0] rd_data, redirect_pc;
  logic [2:0]  exc_cause;

  int tests = 0, fails = 0;

  localparam logic [15:0] A_SR = 16'h0011, A_PPC = 16'h0012, A_DSR = 16'h0014,
                          A_EPC = 16'h0020, A_USR = 16'h0030, A_ESR = 16'h0040;

  always #4 clk = ~clk;

  priv_spr_unit u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .instr_valid(instr_valid),
    .instr_class(instr_class), .cur_pc(cur_pc), .rd_valid(rd_valid),
    .rd_data(rd_data), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .supervisor(supervisor)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic op_req(input logic w, input logic [15:0] a, input logic [31:0] d,
                        input logic [31:0] pc);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; cur_pc = pc;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic op_instr(input logic [1:0] cls, input logic [31:0] pc);
    @(negedge clk);
    instr_valid = 1'b1; instr_class = cls; cur_pc = pc;
    @(negedge clk);
    instr_valid = 1'b0; instr_class = 2'd0;
  endtask

  task automatic go_user();
    op_req(1'b1, A_SR, 32'h0, 32'h0);
    chk("R3 SR write lowers mode", {31'd0, supervisor}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 exc_valid idle", {31'd0, exc_valid}, 32'd0);
    chk("R1 redirect idle", {31'd0, redirect_valid}, 32'd0);
    chk("R1 rd_valid idle", {31'd0, rd_valid}, 32'd0);
    chk("R1 supervisor at reset", {31'd0, supervisor}, 32'd1);
    op_req(1'b0, A_SR, 0, 0);
    chk("R1 SR reset value", rd_data, 32'h8001);
  endtask

  task automatic t_sup_rw();
    op_req(1'b1, A_DSR, 32'h5A5A, 0);
    chk("R3 write no exc", {31'd0, exc_valid}, 32'd0);
    op_req(1'b0, A_DSR, 0, 0);
    chk("R3 DSR readback", rd_data, 32'h5A5A);
    chk("R3 rd_valid", {31'd0, rd_valid}, 32'd1);
    op_req(1'b1, A_EPC, 32'h1234, 0);
    op_req(1'b0, A_EPC, 0, 0);
    chk("R3 EPC readback", rd_data, 32'h1234);
  endtask

  task automatic t_unimpl();
    op_req(1'b0, 16'h0015, 0, 32'h50);
    chk("R2 hole exc", {31'd0, exc_valid}, 32'd1);
    chk("R2 hole cause", {29'd0, exc_cause}, 32'd3);
    chk("R2 hole data zero", rd_data, 32'd0);
    op_req(1'b0, 16'h0811, 0, 32'h54);
    chk("R2 foreign group cause", {29'd0, exc_cause}, 32'd3);
    chk("R2 foreign group data", rd_data, 32'd0);
  endtask

  task automatic t_user_read();
    go_user();
    op_req(1'b0, A_SR, 0, 32'h1000);
    chk("R4 user read cause", {29'd0, exc_cause}, 32'd1);
    chk("R4 user read data zero", rd_data, 32'd0);
    chk("R4 user read rd_valid", {31'd0, rd_valid}, 32'd1);
    chk("R10 entered supervisor", {31'd0, supervisor}, 32'd1);
    chk("R7 vector", redirect_pc, 32'h200);
    op_req(1'b0, A_ESR, 0, 0);
    chk("R7 saved SR", rd_data, 32'h8000);
    op_req(1'b0, A_EPC, 0, 0);
    chk("R7 saved PC", rd_data, 32'h1000);
  endtask

  task automatic t_user_write();
    go_user();
    op_req(1'b1, A_DSR, 32'hFFFF, 32'h1100);
    chk("R5 DSR write cause", {29'd0, exc_cause}, 32'd1);
    op_req(1'b0, A_DSR, 0, 0);
    chk("R5 DSR unchanged", rd_data, 32'h5A5A);
    go_user();
    op_req(1'b1, A_SR, 32'h8001, 32'h1104);
    chk("R5 SR write cause", {29'd0, exc_cause}, 32'd1);
    op_req(1'b0, A_ESR, 0, 0);
    chk("R5 SR not written before entry", rd_data, 32'h8000);
    go_user();
    op_req(1'b1, A_EPC, 32'hDEAD, 32'h1200);
    op_req(1'b0, A_EPC, 0, 0);
    chk("R5 EPC holds entry PC", rd_data, 32'h1200);
  endtask

  task automatic t_scratch();
    go_user();
    op_req(1'b1, A_USR, 32'h77, 0);
    chk("R6 user scratch write no exc", {31'd0, exc_valid}, 32'd0);
    op_req(1'b0, A_USR, 0, 0);
    chk("R6 user scratch read", rd_data, 32'h77);
    chk("R6 no exc on read", {31'd0, exc_valid}, 32'd0);
    chk("R6 still user", {31'd0, supervisor}, 32'd0);
  endtask

  task automatic t_trap();
    op_instr(2'd1, 32'h1004);
    chk("R7 trap cause", {29'd0, exc_cause}, 32'd4);
    chk("R7 trap redirect", {31'd0, redirect_valid}, 32'd1);
    chk("R7 trap vector", redirect_pc, 32'h200);
    chk("R7 trap supervisor", {31'd0, supervisor}, 32'd1);
    op_req(1'b0, A_ESR, 0, 0);
    chk("R7 trap ESR", rd_data, 32'h8000);
    op_req(1'b0, A_EPC, 0, 0);
    chk("R7 trap EPC", rd_data, 32'h1004);
    go_user();
    op_instr(2'd2, 32'h1010);
    chk("R7 syscall cause", {29'd0, exc_cause}, 32'd5);
    chk("R7 syscall supervisor", {31'd0, supervisor}, 32'd1);
  endtask

  task automatic t_rfe_user();
    go_user();
    op_instr(2'd3, 32'h1300);
    chk("R8 user rfe cause", {29'd0, exc_cause}, 32'd2);
    chk("R8 user rfe supervisor", {31'd0, supervisor}, 32'd1);
  endtask

  task automatic t_rfe_sup();
    op_req(1'b1, A_ESR, 32'h0, 0);
    op_req(1'b1, A_EPC, 32'h3000, 0);
    op_instr(2'd3, 32'h2000);
    chk("R9 rfe no exc", {31'd0, exc_valid}, 32'd0);
    chk("R9 rfe redirect", {31'd0, redirect_valid}, 32'd1);
    chk("R9 rfe target", redirect_pc, 32'h3000);
    chk("R9 rfe drops mode", {31'd0, supervisor}, 32'd0);
    op_req(1'b0, A_SR, 0, 32'h3000);
    chk("R9 user after rfe", {29'd0, exc_cause}, 32'd1);
    op_req(1'b1, A_ESR, 32'h1, 0);
    op_instr(2'd3, 32'h2004);
    chk("R9 rfe keeps supervisor", {31'd0, supervisor}, 32'd1);
    op_req(1'b0, A_SR, 0, 0);
    chk("R9 SR bit15 forced", rd_data, 32'h8001);
  endtask

  task automatic t_ppc();
    op_instr(2'd0, 32'h4444);
    chk("R11 other no exc", {31'd0, exc_valid}, 32'd0);
    chk("R11 other no redirect", {31'd0, redirect_valid}, 32'd0);
    op_req(1'b0, A_PPC, 0, 0);
    chk("R11 PPC value", rd_data, 32'h4444);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sup_rw();
    t_unimpl();
    t_user_read();
    t_user_write();
    t_scratch();
    t_trap();
    t_rfe_user();
    t_rfe_sup();
    t_ppc();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule